// File: doc/BRIEF.md
# Clock Root Configuration Controller

This block holds the configuration of one clock root behind a small synchronous register port. Software writes a source selector, a half-integer pre-divider value, a divider mode and the fractional M, N and D values into shadow registers. Those values reach the active configuration outputs only when software sets an update request bit in the command register. The block then copies every shadow field to the active set in one cycle, clears the dirty flags and lowers the request bit on the following cycle.

The command register also holds a force-on control for the root clock. It also has a status bit that reads 1 while the root clock is stopped. That status bit comes from an asynchronous root-running input, which passes through a two-flop synchronizer. The glitch-free source switch and the divider datapaths sit downstream and use the active outputs.

Top module: `clk_root_cfg`

## Requirements
- R1: After reset, every active output and every shadow register is 0: source 0, divider 0 (bypass), mode 0 (M/N bypassed), M, N and D all 0. The command register shows no pending update and no dirty flags.
- R2: A write to config (0x4), M (0x8), N (0xC) or D (0x10) changes only the shadow copy, and a read of that offset returns the shadow value. The active outputs keep their values until a commit takes place.
- R3: In config, only these bits are stored: the pre-divider in bits DIV_W-1:0, the source in bits 10:8, the mode in bits 13:12 and the hardware-control bit in bit 20. All other bits read 0. In M, N and D, bits at or above MND_W are dropped and read 0.
- R4: A write to a configuration register sets that register's dirty flag in the command register (0x0): bit 4 for config, bit 5 for N, bit 6 for M, bit 7 for D.
- R5: Writing 1 to command bit 0 sets the update request. On the next clock edge all shadow values are copied to the active outputs and all dirty flags are cleared. The request bit clears one edge after that.
- R6: Command bit 1 can be read and written. It drives `root_force_on`.
- R7: Command bit 31 reads as the inverse of `root_running_i`, delayed by two clock edges.
- R8: If a configuration write falls on the same edge as the commit copy, the copy takes the shadow value from before the write. The written register keeps its dirty flag set and holds the new value for the next commit.
- R9: Writes to command bits other than 0 and 1 are ignored. A write to an unmapped offset changes nothing, and an unmapped offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| root_running_i | input | 1 | Asynchronous indication that the root clock runs |
| root_force_on | output | 1 | Force the root clock on |
| act_src_sel | output | 3 | Active source selector |
| act_div | output | DIV_W | Active half-integer pre-divider code |
| act_mode | output | 2 | Active divider mode (2 = dual-edge M/N) |
| act_hw_ctrl | output | 1 | Active hardware clock control bit |
| act_m | output | MND_W | Active M value |
| act_n | output | MND_W | Active N value |
| act_d | output | MND_W | Active D value |

## Verification
The shadow write and the commit copy can land on the same clock edge. This conflict is forced by writing the update bit and then, on the very next cycle, writing new data to M. After that edge the bench checks three things. The active M output must still hold the old shadow value. The M dirty flag must stay set while the other flags have cleared. A second commit must then deliver the new M value.

// File: rtl/clk_root_cfg_pkg.sv
`timescale 1ns/1ps
package clk_root_cfg_pkg;
  localparam int REG_AW = 5;

  localparam logic [REG_AW-1:0] OFS_CMD = 5'h00;
  localparam logic [REG_AW-1:0] OFS_CFG = 5'h04;
  localparam logic [REG_AW-1:0] OFS_M   = 5'h08;
  localparam logic [REG_AW-1:0] OFS_N   = 5'h0C;
  localparam logic [REG_AW-1:0] OFS_D   = 5'h10;

  // dirty flag i sits at command bit DIRTY_LSB+i
  localparam int DIRTY_CNT = 4;
  localparam int DIRTY_LSB = 4;
  localparam logic [REG_AW-1:0] DIRTY_OFS [DIRTY_CNT] = '{OFS_CFG, OFS_N, OFS_M, OFS_D};

  localparam int CMD_UPD_BIT   = 0;
  localparam int CMD_FORCE_BIT = 1;
  localparam int CMD_OFF_BIT   = 31;

  localparam int CFG_SRC_LSB  = 8;
  localparam int CFG_MODE_LSB = 12;
  localparam int CFG_HWC_BIT  = 20;

  typedef struct packed {
    logic [2:0] src;
    logic [1:0] mode;
    logic       hwc;
  } cfg_ctl_t;

  // config readback: pre-divider at the bottom, fixed fields above it
  function automatic logic [31:0] pack_cfg(logic [31:0] div_ext, cfg_ctl_t c);
    logic [31:0] w;
    w = div_ext;
    w[CFG_SRC_LSB +: 3]  = c.src;
    w[CFG_MODE_LSB +: 2] = c.mode;
    w[CFG_HWC_BIT]       = c.hwc;
    return w;
  endfunction

  function automatic cfg_ctl_t unpack_ctl(logic [31:0] w);
    cfg_ctl_t c;
    c.src  = w[CFG_SRC_LSB +: 3];
    c.mode = w[CFG_MODE_LSB +: 2];
    c.hwc  = w[CFG_HWC_BIT];
    return c;
  endfunction
endpackage

// File: rtl/rcfg_sync.sv
`timescale 1ns/1ps
module rcfg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d_async};
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/rcfg_shadow.sv
`timescale 1ns/1ps
module rcfg_shadow
  import clk_root_cfg_pkg::*;
#(
  parameter int DIV_W = 5,
  parameter int MND_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [REG_AW-1:0]    addr,
  input  logic [31:0]          wdata,
  input  logic                 commit_fire,
  output logic [DIV_W-1:0]     shd_div,
  output cfg_ctl_t             shd_ctl,
  output logic [MND_W-1:0]     shd_m,
  output logic [MND_W-1:0]     shd_n,
  output logic [MND_W-1:0]     shd_d,
  output logic [DIRTY_CNT-1:0] dirty
);
  logic [DIRTY_CNT-1:0] hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shd_div <= '0;
      shd_ctl <= '0;
      shd_m   <= '0;
      shd_n   <= '0;
      shd_d   <= '0;
    end else if (wr_en) begin
      if (addr == OFS_CFG) begin
        shd_div <= wdata[DIV_W-1:0];
        shd_ctl <= unpack_ctl(wdata);
      end
      if (addr == OFS_M) shd_m <= wdata[MND_W-1:0];
      if (addr == OFS_N) shd_n <= wdata[MND_W-1:0];
      if (addr == OFS_D) shd_d <= wdata[MND_W-1:0];
    end
  end

  // one dirty flag per register; a write on the commit edge keeps it set
  for (genvar g = 0; g < DIRTY_CNT; g++) begin : g_dirty
    assign hit[g] = wr_en && (addr == DIRTY_OFS[g]);
    always_ff @(posedge clk) begin
      if (!rst_n)           dirty[g] <= 1'b0;
      else if (hit[g])      dirty[g] <= 1'b1;
      else if (commit_fire) dirty[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/rcfg_commit.sv
`timescale 1ns/1ps
module rcfg_commit
  import clk_root_cfg_pkg::*;
#(
  parameter int DIV_W = 5,
  parameter int MND_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_req,
  input  logic [DIV_W-1:0] shd_div,
  input  cfg_ctl_t         shd_ctl,
  input  logic [MND_W-1:0] shd_m,
  input  logic [MND_W-1:0] shd_n,
  input  logic [MND_W-1:0] shd_d,
  output logic             upd_pend,
  output logic             commit_fire,
  output logic [DIV_W-1:0] act_div,
  output cfg_ctl_t         act_ctl,
  output logic [MND_W-1:0] act_m,
  output logic [MND_W-1:0] act_n,
  output logic [MND_W-1:0] act_d
);
  logic copied;

  assign commit_fire = upd_pend && !copied;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upd_pend <= 1'b0;
      copied   <= 1'b0;
    end else begin
      upd_pend <= upd_req || (upd_pend && !copied);
      copied   <= commit_fire && !upd_req;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_div <= '0;
      act_ctl <= '0;
      act_m   <= '0;
      act_n   <= '0;
      act_d   <= '0;
    end else if (commit_fire) begin
      act_div <= shd_div;
      act_ctl <= shd_ctl;
      act_m   <= shd_m;
      act_n   <= shd_n;
      act_d   <= shd_d;
    end
  end
endmodule

// File: rtl/clk_root_cfg.sv
`timescale 1ns/1ps
module clk_root_cfg
  import clk_root_cfg_pkg::*;
#(
  parameter int DIV_W = 5,
  parameter int MND_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [4:0]       addr,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  input  logic             root_running_i,
  output logic             root_force_on,
  output logic [2:0]       act_src_sel,
  output logic [DIV_W-1:0] act_div,
  output logic [1:0]       act_mode,
  output logic             act_hw_ctrl,
  output logic [MND_W-1:0] act_m,
  output logic [MND_W-1:0] act_n,
  output logic [MND_W-1:0] act_d
);
  logic                 cmd_wr;
  logic                 upd_req;
  logic                 upd_pend;
  logic                 commit_fire;
  logic                 run_sync;
  logic                 force_en;
  logic [DIRTY_CNT-1:0] dirty;
  logic [DIV_W-1:0]     shd_div;
  cfg_ctl_t             shd_ctl;
  cfg_ctl_t             act_ctl;
  logic [MND_W-1:0]     shd_m, shd_n, shd_d;

  assign cmd_wr  = wr_en && (addr == OFS_CMD);
  assign upd_req = cmd_wr && wdata[CMD_UPD_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n)      force_en <= 1'b0;
    else if (cmd_wr) force_en <= wdata[CMD_FORCE_BIT];
  end
  assign root_force_on = force_en;

  rcfg_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(root_running_i), .q_sync(run_sync)
  );

  rcfg_shadow #(.DIV_W(DIV_W), .MND_W(MND_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .commit_fire(commit_fire), .shd_div(shd_div), .shd_ctl(shd_ctl),
    .shd_m(shd_m), .shd_n(shd_n), .shd_d(shd_d), .dirty(dirty)
  );

  rcfg_commit #(.DIV_W(DIV_W), .MND_W(MND_W)) u_commit (
    .clk(clk), .rst_n(rst_n), .upd_req(upd_req),
    .shd_div(shd_div), .shd_ctl(shd_ctl), .shd_m(shd_m), .shd_n(shd_n), .shd_d(shd_d),
    .upd_pend(upd_pend), .commit_fire(commit_fire),
    .act_div(act_div), .act_ctl(act_ctl), .act_m(act_m), .act_n(act_n), .act_d(act_d)
  );

  assign act_src_sel = act_ctl.src;
  assign act_mode    = act_ctl.mode;
  assign act_hw_ctrl = act_ctl.hwc;

  always_comb begin
    rdata = '0;
    case (addr)
      OFS_CMD: begin
        rdata[CMD_UPD_BIT]                 = upd_pend;
        rdata[CMD_FORCE_BIT]               = force_en;
        rdata[DIRTY_LSB +: DIRTY_CNT]      = dirty;
        rdata[CMD_OFF_BIT]                 = !run_sync;
      end
      OFS_CFG: rdata = pack_cfg(32'(shd_div), shd_ctl);
      OFS_M:   rdata = 32'(shd_m);
      OFS_N:   rdata = 32'(shd_n);
      OFS_D:   rdata = 32'(shd_d);
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/clk_root_cfg_chk.sv
`timescale 1ns/1ps
module clk_root_cfg_chk
  import clk_root_cfg_pkg::*;
#(
  parameter int DIV_W = 5,
  parameter int MND_W = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic [4:0]           addr,
  input logic [31:0]          wdata,
  input logic                 commit_fire,
  input logic [DIRTY_CNT-1:0] dirty,
  input logic [DIV_W-1:0]     shd_div,
  input logic [MND_W-1:0]     shd_m,
  input logic [MND_W-1:0]     shd_n,
  input logic [DIV_W-1:0]     act_div,
  input logic [2:0]           act_src_sel,
  input logic [MND_W-1:0]     act_m,
  input logic [MND_W-1:0]     act_n,
  input logic [MND_W-1:0]     act_d,
  input logic                 root_force_on
);
  logic shd_wr;
  assign shd_wr = wr_en && (addr == OFS_CFG || addr == OFS_M || addr == OFS_N || addr == OFS_D);

  p_hold_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_fire |=> $stable(act_m) && $stable(act_n) && $stable(act_d)
                     && $stable(act_div) && $stable(act_src_sel));

  p_dirty_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_M) |=> dirty[2]);

  p_dirty_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_fire && !shd_wr) |=> (dirty == '0));

  p_copy_shadow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    commit_fire |=> (act_m == $past(shd_m)) && (act_n == $past(shd_n))
                    && (act_div == $past(shd_div)));

  p_single_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    commit_fire |=> !commit_fire);

  p_force_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_CMD) |=> (root_force_on == $past(wdata[CMD_FORCE_BIT])));

  p_collision_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_fire && wr_en && addr == OFS_M) |=> dirty[2] && (act_m == $past(shd_m)));
endmodule

bind clk_root_cfg clk_root_cfg_chk #(.DIV_W(DIV_W), .MND_W(MND_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .commit_fire(commit_fire), .dirty(dirty), .shd_div(shd_div), .shd_m(shd_m),
  .shd_n(shd_n), .act_div(act_div), .act_src_sel(act_src_sel), .act_m(act_m),
  .act_n(act_n), .act_d(act_d), .root_force_on(root_force_on)
);

// File: tb/sim_clk_root_cfg.sv
`timescale 1ns/1ps
module sim_clk_root_cfg;
  localparam int DIV_W = 5;
  localparam int MND_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic [4:0]       addr = '0;
  logic [31:0]      wdata = '0;
  logic [31:0]      rdata;
  logic             root_running_i = 1'b0;
  logic             root_force_on;
  logic [2:0]       act_src_sel;
  logic [DIV_W-1:0] act_div;
  logic [1:0]       act_mode;
  logic             act_hw_ctrl;
  logic [MND_W-1:0] act_m, act_n, act_d;

  int n_chk = 0;
  int n_fail = 0;

  clk_root_cfg #(.DIV_W(DIV_W), .MND_W(MND_W)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .root_running_i(root_running_i), .root_force_on(root_force_on),
    .act_src_sel(act_src_sel), .act_div(act_div), .act_mode(act_mode),
    .act_hw_ctrl(act_hw_ctrl), .act_m(act_m), .act_n(act_n), .act_d(act_d)
  );

  always #5 clk = ~clk;

  // {offset, write data, expected readback}
  localparam logic [68:0] VEC [7] = '{
    {5'h04, 32'hFFFF_FFFF, 32'h0010_371F},
    {5'h04, 32'h0000_2103, 32'h0000_2103},
    {5'h08, 32'h0000_0301, 32'h0000_0001},
    {5'h0C, 32'hFFFF_FFFC, 32'h0000_00FC},
    {5'h10, 32'h0000_00FD, 32'h0000_00FD},
    {5'h14, 32'hFFFF_FFFF, 32'h0000_0000},
    {5'h08, 32'h1234_5607, 32'h0000_0007}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // called at a falling edge; the write lands on the next rising edge
  task automatic wr(logic [4:0] a, logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(5'h00, r); check("R1 cmd", r, 32'h8000_0000);
    rd(5'h04, r); check("R1 cfg", r, 32'h0);
    rd(5'h0C, r); check("R1 n", r, 32'h0);
    check("R1 actives", {act_src_sel, act_mode, act_hw_ctrl, 3'b0, act_div, act_m, act_n, act_d},
          32'h0);

    // R2 R3 R9 table of writes and readbacks
    for (int i = 0; i < 7; i++) begin
      wr(VEC[i][68:64], VEC[i][63:32]);
      rd(VEC[i][68:64], r);
      check("R3 readback", r, VEC[i][31:0]);
      check("R2 active held", {8'h0, act_m, act_n, act_d}, 32'h0);
    end

    // R4 all dirty flags set, R9 unmapped write left command untouched
    rd(5'h00, r); check("R4 dirty all", r, 32'h8000_00F0);

    // R5 commit
    wr(5'h00, 32'h1);
    rd(5'h00, r); check("R5 pending", r, 32'h8000_00F1);
    check("R5 not yet copied", {24'h0, act_m}, 32'h0);
    @(negedge clk);
    check("R5 copy m n d", {8'h0, act_m, act_n, act_d}, 32'h0007_FCFD);
    check("R5 copy cfg", {26'h0, act_src_sel, act_mode, act_hw_ctrl} , {26'h0, 3'd1, 2'd2, 1'b0});
    check("R5 copy div", 32'(act_div), 32'h3);
    rd(5'h00, r); check("R5 dirty cleared", r, 32'h8000_0001);
    @(negedge clk);
    rd(5'h00, r); check("R5 update cleared", r, 32'h8000_0000);

    // R4 single dirty flag
    wr(5'h0C, 32'h11);
    rd(5'h00, r); check("R4 n dirty only", r, 32'h8000_0020);
    check("R2 n active held", 32'(act_n), 32'hFC);

    // R8 collision: write to M on the copy edge
    wr(5'h00, 32'h1);
    wr(5'h08, 32'h22);
    check("R8 old m copied", 32'(act_m), 32'h07);
    check("R8 n copied", 32'(act_n), 32'h11);
    rd(5'h00, r); check("R8 m dirty kept", r, 32'h8000_0041);
    @(negedge clk);
    rd(5'h00, r); check("R8 after clear", r, 32'h8000_0040);
    wr(5'h00, 32'h1);
    @(negedge clk);
    check("R8 new m committed", 32'(act_m), 32'h22);
    @(negedge clk);

    // R6 force on, R9 read-only command bits
    wr(5'h00, 32'hF000_00F2);
    check("R6 force out", 32'(root_force_on), 32'h1);
    rd(5'h00, r); check("R9 ro bits", r, 32'h8000_0002);

    // R7 synchronized status
    root_running_i = 1'b1;
    @(negedge clk);
    rd(5'h00, r); check("R7 one edge", r, 32'h8000_0002);
    @(negedge clk);
    rd(5'h00, r); check("R7 two edges", r, 32'h0000_0002);
    wr(5'h00, 32'h0);
    check("R6 force off", 32'(root_force_on), 32'h0);

    // R1 reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    root_running_i = 1'b0;
    check("R1 reset actives", {8'h0, act_m, act_n, act_d}, 32'h0);
    rd(5'h08, r); check("R1 reset shadow m", r, 32'h0);

    finish_run();
  end
endmodule